// File: doc/BRIEF.md
# Host Parallel Byte Handshake Port

This block lets an external host exchange single bytes with an embedded processor over an 8-bit bidirectional bus. The host drives two control lines: an active-low strobe and a direction line (high = host reads, low = host writes). The block answers on two active-low ready lines, one for each direction. The local processor arms a direction by writing a one and then a zero to a control bit. The 1-to-0 change of that bit makes the ready line for that direction go low.

For a host write, the block captures the bus byte when the strobe rises. It then releases the write-ready line and pulses a write-done interrupt. For a host read, the processor first loads an outbound byte. The block drives that byte onto the bus while the strobe is low, and finishes on the strobe's rising edge with a read-done interrupt.

A mode bit places the port in master mode. There the handshake is off, both ready lines rest high, and the bus is never driven. The mode bit comes out of reset in slave mode. Strobe and direction cross into the processor clock through two-flop synchronisers, so every host edge takes effect three clock edges after it occurs.

Top module: `hps_link`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released: `in_rdy_n` and `out_rdy_n` are 1, both interrupts are 0, `host_doe` is 0, `master_mode` is 0 and `rx_data` is 0.
- R2: In slave mode, a control write that changes bit 0 of the control register from 1 to 0 drives `in_rdy_n` low on the edge of that write. Such a write has no effect if the write side is already armed.
- R3: A host write completes when a strobe rising edge arrives while direction is low and `in_rdy_n` is low. On the third clock edge after the strobe rises, the block captures `host_din` into `rx_data` and drives `in_rdy_n` high. `rx_data` changes at no other time.
- R4: `irq_wr_done` is high for exactly the one cycle in which `in_rdy_n` has just risen because a host write completed.
- R5: In slave mode, a control write that changes bit 1 from 1 to 0 drives `out_rdy_n` low on the edge of that write. The byte sent to the host is the last value written through `tx_we`.
- R6: `host_doe` is high only in slave mode while the synchronised direction is high and the synchronised strobe is low. During that time `host_dout` equals the outbound byte.
- R7: A host read completes when a strobe rising edge arrives while direction is high and `out_rdy_n` is low. `out_rdy_n` then rises on the third clock edge after the strobe rises, and `irq_rd_done` is high for that one cycle.
- R8: Writing the mode bit (`mode_we`) never raises either interrupt.
- R9: Writing 1 to the mode bit enters master mode on that edge. In master mode both ready lines are forced high, arming writes are ignored, strobes cause no interrupt and `host_doe` stays 0. Writing 0 returns the port to slave mode.
- R10: A strobe rising edge is ignored, with no interrupt and no change to `rx_data`, in two cases: when the ready line of the selected direction is high, or when the direction does not match the armed side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control bits: bit 0 arms host write, bit 1 arms host read |
| mode_we | input | 1 | Mode bit write strobe |
| mode_wdata | input | 1 | Mode value, 1 = master, 0 = slave |
| tx_we | input | 1 | Outbound byte write strobe |
| tx_wdata | input | DW | Outbound byte |
| rx_data | output | DW | Last byte received from the host |
| master_mode | output | 1 | High in master mode, used to switch the pins to general I/O |
| irq_wr_done | output | 1 | One-cycle pulse when a host write completes |
| irq_rd_done | output | 1 | One-cycle pulse when a host read completes |
| host_strobe_n | input | 1 | Host strobe, active low |
| host_rw | input | 1 | Host direction, 1 = read, 0 = write |
| host_din | input | DW | Bus value at the pins |
| host_dout | output | DW | Bus value driven during host reads |
| host_doe | output | 1 | Bus output enable |
| in_rdy_n | output | 1 | Ready for a host write, active low |
| out_rdy_n | output | 1 | Ready for a host read, active low |

## Verification
The assertions assume the host holds the direction line steady from before the strobe falls until after it rises. They also assume the strobe stays low for at least three clock cycles, and that the host holds `host_din` stable until the ready line reacts. The stimulus changes all host lines only on falling clock edges. It sets the direction and the data two cycles before the strobe falls, keeps the strobe low for four cycles, and holds the bus until the completion has been observed. Random transfers draw the direction, the arming and the byte from a fixed seed, so mismatched and unarmed strobes occur along with proper transfers.

// File: rtl/hps_link.sv
module hps_link #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [1:0]    ctl_wdata,
  input  logic          mode_we,
  input  logic          mode_wdata,
  input  logic          tx_we,
  input  logic [DW-1:0] tx_wdata,
  output logic [DW-1:0] rx_data,
  output logic          master_mode,
  output logic          irq_wr_done,
  output logic          irq_rd_done,
  input  logic          host_strobe_n,
  input  logic          host_rw,
  input  logic [DW-1:0] host_din,
  output logic [DW-1:0] host_dout,
  output logic          host_doe,
  output logic          in_rdy_n,
  output logic          out_rdy_n
);

  logic [1:0]    ctl_q;
  logic          stb_s1, stb_s2, stb_s3;
  logic          rw_s1, rw_s2;
  logic          wr_arm, rd_arm, master_q;
  logic [DW-1:0] tx_q, rx_q;
  logic          irq_wr_q, irq_rd_q;

  logic stb_rise, wr_done, rd_done, arm_wr, arm_rd, go_master;

  assign stb_rise  = stb_s2 & ~stb_s3;
  assign wr_done   = stb_rise & ~rw_s2 & wr_arm & ~master_q;
  assign rd_done   = stb_rise &  rw_s2 & rd_arm & ~master_q;
  assign arm_wr    = ctl_we & ctl_q[0] & ~ctl_wdata[0] & ~master_q & ~wr_arm;
  assign arm_rd    = ctl_we & ctl_q[1] & ~ctl_wdata[1] & ~master_q & ~rd_arm;
  assign go_master = mode_we & mode_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_s1 <= 1'b1;
      stb_s2 <= 1'b1;
      stb_s3 <= 1'b1;
      rw_s1  <= 1'b0;
      rw_s2  <= 1'b0;
    end else begin
      stb_s1 <= host_strobe_n;
      stb_s2 <= stb_s1;
      stb_s3 <= stb_s2;
      rw_s1  <= host_rw;
      rw_s2  <= rw_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      master_q <= 1'b0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      if (ctl_we)  ctl_q    <= ctl_wdata;
      if (mode_we) master_q <= mode_wdata;
      if (tx_we)   tx_q     <= tx_wdata;
      if (wr_done) rx_q     <= host_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_arm   <= 1'b0;
      rd_arm   <= 1'b0;
      irq_wr_q <= 1'b0;
      irq_rd_q <= 1'b0;
    end else begin
      irq_wr_q <= wr_done;
      irq_rd_q <= rd_done;
      if (go_master || wr_done) wr_arm <= 1'b0;
      else if (arm_wr)          wr_arm <= 1'b1;
      if (go_master || rd_done) rd_arm <= 1'b0;
      else if (arm_rd)          rd_arm <= 1'b1;
    end
  end

  assign in_rdy_n    = ~wr_arm;
  assign out_rdy_n   = ~rd_arm;
  assign irq_wr_done = irq_wr_q;
  assign irq_rd_done = irq_rd_q;
  assign rx_data     = rx_q;
  assign master_mode = master_q;
  assign host_dout   = tx_q;
  assign host_doe    = ~master_q & rw_s2 & ~stb_s2;

  // R2
  p_arm_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_q[0] && !ctl_wdata[0] && !master_mode && !mode_we && in_rdy_n) |=> !in_rdy_n);

  // R5
  p_arm_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_q[1] && !ctl_wdata[1] && !master_mode && !mode_we && out_rdy_n) |=> !out_rdy_n);

  // R3
  p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_wr_done |-> $stable(rx_data));

  // R4
  p_wr_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(in_rdy_n) && !master_mode) |-> irq_wr_done);

  p_wr_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_wr_done |-> (in_rdy_n && $past(!in_rdy_n)));

  // R7
  p_rd_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rd_done |-> (out_rdy_n && $past(!out_rdy_n)));

  p_rd_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_rdy_n) && !master_mode) |-> irq_rd_done);

  // R6
  p_doe_cond_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_doe |-> (!master_mode && $past(host_rw, 2) && !$past(host_strobe_n, 2)));

  // R9
  p_master_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && $past(master_mode)) |->
      (in_rdy_n && out_rdy_n && !irq_wr_done && !irq_rd_done && !host_doe));

endmodule

// File: tb/hps_link_tb_top.sv
module hps_link_tb_top;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ctl_we, mode_we, mode_wdata, tx_we;
  logic [1:0]    ctl_wdata;
  logic [DW-1:0] tx_wdata, rx_data, host_din, host_dout;
  logic          master_mode, irq_wr_done, irq_rd_done;
  logic          host_strobe_n, host_rw, host_doe, in_rdy_n, out_rdy_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [1:0]    ctl_shadow;
  bit            exp_wr_arm, exp_rd_arm, exp_master;
  logic [DW-1:0] exp_rx, exp_tx;

  always #10 clk = ~clk;

  hps_link #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .tx_we(tx_we), .tx_wdata(tx_wdata),
    .rx_data(rx_data), .master_mode(master_mode),
    .irq_wr_done(irq_wr_done), .irq_rd_done(irq_rd_done),
    .host_strobe_n(host_strobe_n), .host_rw(host_rw),
    .host_din(host_din), .host_dout(host_dout), .host_doe(host_doe),
    .in_rdy_n(in_rdy_n), .out_rdy_n(out_rdy_n)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit completes(bit armed, bit master);
    return armed && !master;
  endfunction

  task automatic ctl_write(logic [1:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
    if (!exp_master) begin
      if (ctl_shadow[0] && !v[0]) exp_wr_arm = 1'b1;
      if (ctl_shadow[1] && !v[1]) exp_rd_arm = 1'b1;
    end
    ctl_shadow = v;
  endtask

  task automatic mode_write(bit m);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = m;
    @(negedge clk);
    mode_we = 1'b0;
    chk("R8 irq_wr", irq_wr_done, 0);
    chk("R8 irq_rd", irq_rd_done, 0);
    exp_master = m;
    if (m) begin exp_wr_arm = 0; exp_rd_arm = 0; end
  endtask

  task automatic tx_load(logic [DW-1:0] b);
    @(negedge clk);
    tx_we = 1'b1; tx_wdata = b;
    @(negedge clk);
    tx_we = 1'b0;
    exp_tx = b;
  endtask

  task automatic host_xfer(bit rd, logic [DW-1:0] b);
    bit wfin, rfin;
    @(negedge clk);
    host_rw = rd; host_din = b;
    repeat (2) @(negedge clk);
    host_strobe_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R6 doe", host_doe, rd && !exp_master);
    if (rd && !exp_master) chk("R6 dout", host_dout, exp_tx);
    host_strobe_n = 1'b1;
    wfin = !rd && completes(exp_wr_arm, exp_master);
    rfin = rd && completes(exp_rd_arm, exp_master);
    repeat (2) @(negedge clk);
    chk("R3 in_rdy latency", in_rdy_n, !exp_wr_arm);
    chk("R7 out_rdy latency", out_rdy_n, !exp_rd_arm);
    chk("R10 no early irq", irq_wr_done | irq_rd_done, 0);
    @(negedge clk);
    if (wfin) begin exp_wr_arm = 0; exp_rx = b; end
    if (rfin) exp_rd_arm = 0;
    chk("R3 in_rdy", in_rdy_n, !exp_wr_arm);
    chk("R7 out_rdy", out_rdy_n, !exp_rd_arm);
    chk("R4 irq_wr", irq_wr_done, wfin);
    chk("R7 irq_rd", irq_rd_done, rfin);
    chk("R3 R10 rx", rx_data, exp_rx);
    chk("R6 doe idle", host_doe, 0);
    @(negedge clk);
    chk("R4 R7 pulse one cycle", irq_wr_done | irq_rd_done, 0);
    host_din = ~b;
  endtask

  task automatic arm(int side);
    logic [1:0] v;
    v = ctl_shadow;
    v[side] = 1'b1;
    ctl_write(v);
    v[side] = 1'b0;
    ctl_write(v);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; ctl_we = 0; ctl_wdata = 0; mode_we = 0; mode_wdata = 0;
    tx_we = 0; tx_wdata = 0; host_strobe_n = 1; host_rw = 0; host_din = 0;
    ctl_shadow = 0; exp_wr_arm = 0; exp_rd_arm = 0; exp_master = 0;
    exp_rx = 0; exp_tx = 0;
    repeat (3) @(negedge clk);
    chk("R1 in_rdy reset", in_rdy_n, 1);
    chk("R1 out_rdy reset", out_rdy_n, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R1 in_rdy", in_rdy_n, 1);
    chk("R1 out_rdy", out_rdy_n, 1);
    chk("R1 irqs", {irq_wr_done, irq_rd_done}, 0);
    chk("R1 doe", host_doe, 0);
    chk("R1 mode", master_mode, 0);
    chk("R1 rx", rx_data, 0);

    arm(0);
    chk("R2 arm write", in_rdy_n, 0);
    chk("R2 other side idle", out_rdy_n, 1);
    host_xfer(0, 8'hA5);

    tx_load(8'h3C);
    arm(1);
    chk("R5 arm read", out_rdy_n, 0);
    host_xfer(1, 8'h00);

    host_xfer(0, 8'h77);
    host_xfer(1, 8'h11);

    arm(0);
    host_xfer(1, 8'h22);
    chk("R10 mismatch keeps armed", in_rdy_n, 0);
    host_xfer(0, 8'h5A);

    arm(0);
    arm(1);
    mode_write(1);
    chk("R9 master flag", master_mode, 1);
    chk("R9 in_rdy forced", in_rdy_n, 1);
    chk("R9 out_rdy forced", out_rdy_n, 1);
    arm(0);
    chk("R9 arm ignored", in_rdy_n, 1);
    host_xfer(1, 8'h99);
    host_xfer(0, 8'h99);
    mode_write(0);
    chk("R9 slave again", master_mode, 0);

    for (int i = 0; i < 60; i++) begin
      bit rd;
      logic [DW-1:0] b;
      rd = $urandom_range(0, 1);
      b  = DW'($urandom);
      if ($urandom_range(0, 3) == 0) tx_load(DW'($urandom));
      if ($urandom_range(0, 2) != 0) arm($urandom_range(0, 1));
      if ($urandom_range(0, 9) == 0) mode_write($urandom_range(0, 1));
      host_xfer(rd, b);
    end
    if (exp_master) mode_write(0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule